// File: doc/BRIEF.md
# Lamp Matrix Auto Scanner

This block refreshes a grid of lamps wired as rows and columns. The grid has up to nine rows and eight columns. A host loads one column pattern per row into an on-chip frame buffer through a plain write port. Once `enable` is high, the scanner visits the rows in turn and repeats the frame for as long as it stays enabled. The host does not have to take part in the refresh.

Each row gets a fixed time slot made of three phases:

- **Blank.** Every row and column output is low for a set number of cycles, so the previous row has fully released before anything new is driven.
- **Setup.** The row's column pattern appears alone for one cycle.
- **Dwell.** The row line is also asserted, for a set number of cycles.

Rows one to eight appear one-hot on a main row byte. The ninth row appears on bit 0 of a separate auxiliary byte. A one-cycle strobe marks the first cycle in which the first row is driven. Downstream logic can use that strobe as a keep-alive that proves the scan is still running.

Top module: `lamp_scan`

## Requirements
- R1: A synchronous reset drives every output low, clears all frame-buffer entries to zero and makes the next scan begin at row index 0.
- R2: While `enable` is low, all outputs are low. The first clock edge with `enable` high starts the scan at row index 0. An edge with `enable` low returns every output to zero after that edge.
- R3: Each row slot begins with `BLANK_CYC` cycles in which `row_main`, `row_aux` and `col` are all zero.
- R4: After the blank phase comes exactly one cycle in which `col` carries the row's pattern while both row bytes are still zero.
- R5: After the setup cycle, `col` keeps the pattern and the row line is asserted for `DWELL_CYC` cycles. Then the next row's blank phase begins.
- R6: Row index i (0 to 7) drives bit i of `row_main`. Row index 8 drives bit 0 of `row_aux`, and `row_main` is zero while it does. For example, a pattern of 0x40 stored at row index 3 produces `row_main`=0x08, `row_aux`=0x00 and `col`=0x40 during that row's dwell.
- R7: At most one bit across `row_main` and `row_aux` is high in any cycle.
- R8: A write with `wr_en` high stores `wr_data` as the column pattern for row index `wr_row`. The pattern shown for a row is the stored value at the edge that ends that row's blank phase, and it stays constant through the rest of the slot. A later write shows up the next time that row is scanned.
- R9: A write whose `wr_row` is not below `NUM_ROWS` (9 to 15 by default) changes no stored pattern.
- R10: `first_row_stb` is high for exactly the first dwell cycle of row index 0, once per frame, and low at all other times.
- R11: Rows are visited in increasing index order 0 to `NUM_ROWS`-1, then wrap back to 0. Each slot lasts `BLANK_CYC`+1+`DWELL_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the scan while high |
| wr_en | input | 1 | Frame-buffer write strobe |
| wr_row | input | 4 | Row index of the write |
| wr_data | input | 8 | Column pattern to store |
| row_main | output | 8 | One-hot row lines for row indices 0 to 7 |
| row_aux | output | 8 | Auxiliary row lines; bit 0 is row index 8 |
| col | output | 8 | Column pattern for the selected row |
| first_row_stb | output | 1 | One-cycle pulse when row index 0 is first driven |

## Verification
A corrupted phase counter or row index shows at the ports within one row slot. It appears as a blank phase of the wrong length, a row line that rises in the same cycle as its column data, or a row visited out of order. A bad frame-buffer entry or a latch taken at the wrong time shows as a wrong `col` value during the next dwell of the affected row, so it appears within one frame. The bench steps a small model of the slot arithmetic every cycle and compares all four outputs in every cycle. It covers full frames, writes made during the scan, writes to indices past the last row, and enable and reset dropped mid-frame.

// File: rtl/lamp_scan_pkg.sv
package lamp_scan_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_BLANK,
        PH_SETUP,
        PH_DWELL
    } scan_phase_e;

endpackage

// File: rtl/lamp_fb.sv
module lamp_fb #(
    parameter int NUM_ROWS = 9,
    parameter int COLS     = 8,
    parameter int ROW_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [COLS-1:0]  wr_data,
    input  logic [ROW_W-1:0] rd_row,
    output logic [COLS-1:0]  rd_data
);

    logic [COLS-1:0] pat_d [NUM_ROWS];
    logic [COLS-1:0] pat_q [NUM_ROWS];

    // one register per row; an index past the last row matches no entry
    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
        always_comb begin
            pat_d[g] = pat_q[g];
            if (wr_en && (wr_row == ROW_W'(g))) begin
                pat_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                pat_q[g] <= '0;
            end else begin
                pat_q[g] <= pat_d[g];
            end
        end
    end

    assign rd_data = pat_q[rd_row];

endmodule

// File: rtl/lamp_seq.sv
module lamp_seq
    import lamp_scan_pkg::*;
#(
    parameter int NUM_ROWS  = 9,
    parameter int ROW_W     = 4,
    parameter int BLANK_CYC = 4,
    parameter int DWELL_CYC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    output logic [ROW_W-1:0] row_idx,
    output logic             ev_clear,
    output logic             ev_load,
    output logic             ev_fire
);

    localparam int MAX_CYC = (BLANK_CYC > DWELL_CYC) ? BLANK_CYC : DWELL_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] BLANK_LAST = CNT_W'(BLANK_CYC - 1);
    localparam logic [CNT_W-1:0] DWELL_LAST = CNT_W'(DWELL_CYC - 1);
    localparam logic [ROW_W-1:0] ROW_LAST   = ROW_W'(NUM_ROWS - 1);

    typedef struct packed {
        scan_phase_e      phase;
        logic [CNT_W-1:0] cnt;
        logic [ROW_W-1:0] row;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        ev_clear = 1'b0;
        ev_load  = 1'b0;
        ev_fire  = 1'b0;
        if (!enable) begin
            s_d.phase = PH_IDLE;
            s_d.row   = '0;
            ev_clear  = 1'b1;
        end else begin
            unique case (s_q.phase)
                PH_IDLE: begin
                    s_d.phase = PH_BLANK;
                    s_d.cnt   = BLANK_LAST;
                    s_d.row   = '0;
                end
                PH_BLANK: begin
                    if (s_q.cnt == '0) begin
                        s_d.phase = PH_SETUP;
                        ev_load   = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
                PH_SETUP: begin
                    s_d.phase = PH_DWELL;
                    s_d.cnt   = DWELL_LAST;
                    ev_fire   = 1'b1;
                end
                PH_DWELL: begin
                    if (s_q.cnt == '0) begin
                        s_d.phase = PH_BLANK;
                        s_d.cnt   = BLANK_LAST;
                        s_d.row   = (s_q.row == ROW_LAST) ? '0 : s_q.row + 1'b1;
                        ev_clear  = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
                default: s_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, row: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign row_idx = s_q.row;

endmodule

// File: rtl/lamp_drive.sv
module lamp_drive #(
    parameter int MAIN_ROWS = 8,
    parameter int AUX_W     = 8,
    parameter int COLS      = 8,
    parameter int ROW_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ev_clear,
    input  logic                 ev_load,
    input  logic                 ev_fire,
    input  logic [ROW_W-1:0]     row_idx,
    input  logic [COLS-1:0]      col_in,
    output logic [MAIN_ROWS-1:0] row_main,
    output logic [AUX_W-1:0]     row_aux,
    output logic [COLS-1:0]      col,
    output logic                 first_row_stb
);

    localparam int ALL_W = MAIN_ROWS + AUX_W;

    typedef struct packed {
        logic [MAIN_ROWS-1:0] main;
        logic [AUX_W-1:0]     aux;
        logic [COLS-1:0]      col;
        logic                 stb;
    } drv_t;

    drv_t d_d, d_q;
    logic [ALL_W-1:0] sel_vec;

    assign sel_vec = ALL_W'(1) << row_idx;

    always_comb begin
        d_d     = d_q;
        d_d.stb = 1'b0;
        if (ev_clear) begin
            d_d.main = '0;
            d_d.aux  = '0;
            d_d.col  = '0;
        end else if (ev_load) begin
            d_d.col = col_in;
        end else if (ev_fire) begin
            d_d.main = sel_vec[MAIN_ROWS-1:0];
            d_d.aux  = sel_vec[ALL_W-1:MAIN_ROWS];
            d_d.stb  = (row_idx == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign row_main      = d_q.main;
    assign row_aux       = d_q.aux;
    assign col           = d_q.col;
    assign first_row_stb = d_q.stb;

endmodule

// File: rtl/lamp_scan.sv
module lamp_scan #(
    parameter int NUM_ROWS  = 9,
    parameter int MAIN_ROWS = 8,
    parameter int AUX_W     = 8,
    parameter int COLS      = 8,
    parameter int ROW_W     = 4,
    parameter int BLANK_CYC = 4,
    parameter int DWELL_CYC = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 wr_en,
    input  logic [ROW_W-1:0]     wr_row,
    input  logic [COLS-1:0]      wr_data,
    output logic [MAIN_ROWS-1:0] row_main,
    output logic [AUX_W-1:0]     row_aux,
    output logic [COLS-1:0]      col,
    output logic                 first_row_stb
);

    logic [ROW_W-1:0] row_idx;
    logic [COLS-1:0]  fb_col;
    logic             ev_clear;
    logic             ev_load;
    logic             ev_fire;

    lamp_fb #(
        .NUM_ROWS(NUM_ROWS),
        .COLS    (COLS),
        .ROW_W   (ROW_W)
    ) u_fb (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_row (wr_row),
        .wr_data(wr_data),
        .rd_row (row_idx),
        .rd_data(fb_col)
    );

    lamp_seq #(
        .NUM_ROWS (NUM_ROWS),
        .ROW_W    (ROW_W),
        .BLANK_CYC(BLANK_CYC),
        .DWELL_CYC(DWELL_CYC)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .row_idx (row_idx),
        .ev_clear(ev_clear),
        .ev_load (ev_load),
        .ev_fire (ev_fire)
    );

    lamp_drive #(
        .MAIN_ROWS(MAIN_ROWS),
        .AUX_W    (AUX_W),
        .COLS     (COLS),
        .ROW_W    (ROW_W)
    ) u_drv (
        .clk          (clk),
        .rst          (rst),
        .ev_clear     (ev_clear),
        .ev_load      (ev_load),
        .ev_fire      (ev_fire),
        .row_idx      (row_idx),
        .col_in       (fb_col),
        .row_main     (row_main),
        .row_aux      (row_aux),
        .col          (col),
        .first_row_stb(first_row_stb)
    );

endmodule

// File: rtl/lamp_scan_chk.sv
module lamp_scan_chk #(
    parameter int MAIN_ROWS = 8,
    parameter int AUX_W     = 8,
    parameter int COLS      = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 enable,
    input logic [MAIN_ROWS-1:0] row_main,
    input logic [AUX_W-1:0]     row_aux,
    input logic [COLS-1:0]      col,
    input logic                 first_row_stb
);

    logic [MAIN_ROWS+AUX_W-1:0] rows_all;
    assign rows_all = {row_aux, row_main};

    p_one_row_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rows_all));

    p_aux_alone_r6: assert property (@(posedge clk) disable iff (rst)
        (|row_aux) |-> (row_main == '0));

    p_col_first_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(|rows_all) |-> ($stable(col) && col == $past(col)));

    p_row_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (|rows_all) |=> (rows_all == '0 || rows_all == $past(rows_all)));

    p_col_steady_r8: assert property (@(posedge clk) disable iff (rst)
        (|rows_all) |=> (rows_all == '0 || $stable(col)));

    p_stb_single_r10: assert property (@(posedge clk) disable iff (rst)
        first_row_stb |=> !first_row_stb);

    p_stb_row0_r10: assert property (@(posedge clk) disable iff (rst)
        first_row_stb |-> (row_main[0] && row_aux == '0));

    p_idle_dark_r2: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (rows_all == '0 && col == '0 && !first_row_stb));

endmodule

bind lamp_scan lamp_scan_chk #(
    .MAIN_ROWS(MAIN_ROWS),
    .AUX_W    (AUX_W),
    .COLS     (COLS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .row_main     (row_main),
    .row_aux      (row_aux),
    .col          (col),
    .first_row_stb(first_row_stb)
);

// File: tb/lamp_scan_test.sv
module lamp_scan_test;

    localparam int N = 9;
    localparam int B = 4;
    localparam int D = 8;
    localparam int P = B + 1 + D;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_row = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] row_main;
    logic [7:0] row_aux;
    logic [7:0] col;
    logic       first_row_stb;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    // bench model state
    bit         active = 1'b0;
    int         k      = 0;
    logic [7:0] mdl_fb [N];
    logic [7:0] lat    = '0;
    string      col_tag = "R8";

    always #4 clk = ~clk;

    lamp_scan #(.BLANK_CYC(B), .DWELL_CYC(D)) uut (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .wr_en        (wr_en),
        .wr_row       (wr_row),
        .wr_data      (wr_data),
        .row_main     (row_main),
        .row_aux      (row_aux),
        .col          (col),
        .first_row_stb(first_row_stb)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // one clock: update model at the edge, then compare just after
    task automatic step();
        int         p;
        int         r;
        logic [7:0]  e_col;
        logic [15:0] e_rows;
        logic        e_stb;
        string       rtag;
        string       ptag;
        @(posedge clk);
        p = 0;
        r = 0;
        if (rst) begin
            active = 1'b0;
            for (int i = 0; i < N; i++) mdl_fb[i] = '0;
        end else begin
            if (!enable) active = 1'b0;
            else if (!active) begin active = 1'b1; k = 0; end
            else k++;
            if (active) begin
                p = k % P;
                r = (k / P) % N;
                if (p == B) lat = mdl_fb[r];
            end
            if (wr_en && int'(wr_row) < N) mdl_fb[wr_row] = wr_data;
        end
        #2;
        e_col  = '0;
        e_rows = '0;
        e_stb  = 1'b0;
        if (active) begin
            if (p >= B)    e_col  = lat;
            if (p > B)     e_rows = 16'(1) << r;
            if (p == B + 1 && r == 0) e_stb = 1'b1;
        end
        if (rst || (!active && k == 0)) ptag = "R1";
        else if (!active) ptag = "R2";
        else if (p < B) ptag = "R3";
        else if (p == B) ptag = "R4";
        else ptag = "R5";
        rtag = (active && r == 8) ? "R6" : ((active && p > B) ? "R11" : ptag);
        check({row_aux, row_main} == e_rows, rtag, {row_aux, row_main}, e_rows);
        check(col == e_col, (active && p >= B) ? col_tag : ptag, col, e_col);
        check(first_row_stb == e_stb, "R10", first_row_stb, e_stb);
        check($countones({row_aux, row_main}) <= 1, "R7", {row_aux, row_main}, 0);
        if (active && r == 3 && p == B + 1 && lat == 8'h40) begin
            // R6 example: row index 3 with pattern 0x40
            check(row_main == 8'h08 && row_aux == 8'h00 && col == 8'h40, "R6",
                  {row_aux, row_main, col}, 24'h000840);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        for (int i = 0; i < N; i++) mdl_fb[i] = '0;
        // R1: reset state
        run(3);
        rst = 1'b0;
        // R2: disabled stays dark
        run(4);
        // load frame buffer, including row 3 = 0x40 for the R6 example
        for (int i = 0; i < N; i++) begin
            wr_en   = 1'b1;
            wr_row  = 4'(i);
            wr_data = (i == 3) ? 8'h40 : 8'(i * 29 + 17);
            step();
        end
        wr_en = 1'b0;
        step();
        // R3 R4 R5 R11: three full frames
        enable = 1'b1;
        run(3 * N * P);
        // R9: writes past the last row during the scan
        col_tag = "R9";
        for (int i = 0; i < N * P + 5; i++) begin
            wr_en   = (i % 3 == 0);
            wr_row  = 4'(9 + (i % 7));
            wr_data = 8'(i * 7 + 1);
            step();
        end
        wr_en = 1'b0;
        run(N * P);
        // R8: writes to valid rows at varying points of the scan
        col_tag = "R8";
        for (int i = 0; i < 2 * N * P; i++) begin
            wr_en   = (i % 5 == 2);
            wr_row  = 4'((i / 5) % N);
            wr_data = 8'(i * 11 + 3);
            step();
        end
        wr_en = 1'b0;
        run(N * P);
        // R2: drop enable mid-frame, then restart at row 0
        run(20);
        enable = 1'b0;
        run(6);
        enable = 1'b1;
        run(N * P + 10);
        // R1: reset mid-scan clears the buffer and restarts
        rst = 1'b1;
        run(2);
        rst = 1'b0;
        run(N * P + 5);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule